// File: doc/BRIEF.md
# Byte/Word Data Port Bridge

This block is the host-visible data window into a packet buffer built from 16-bit memory words. The host moves packet bytes through one data register using word, low-byte or high-byte accesses. Access sizes may change from one access to the next. The byte stream stays in order whether the current pointer is even or odd. Writes enter a small byte queue that packs bytes into memory words. Reads are served from a second byte queue that a prefetcher keeps filled from the buffer.

The host first writes a pointer register. That register holds the byte address to start from and a fixed-address flag. It then streams data through the data register. In the normal mode each access advances the position by the number of bytes moved. In fixed mode the position never moves: every write goes straight to memory, and every read returns the bytes at the pointer. The memory side is a single word port with byte enables and a one-cycle read latency.

Top module: `dport_bridge`

## Requirements
- R1: The access size is set by `hst_addr[0]` and `hst_hbe_n`. 0/0 is a word, 0/1 is a low byte, and 1/0 is a high byte. The combination 1/1 moves no data, reads back as 0, and neither consumes nor advances anything.
- R2: Offsets 0 and 2 (`hst_addr[2]`=0) both reach the data register. Offset 4 (`hst_addr[2]`=1) is the pointer register: bits [PTR_W-1:0] hold the byte pointer and bit 15 sets fixed mode.
- R3: Written bytes land at consecutive byte addresses from the pointer. A word write stores its low lane first and then its high lane. A byte written through either lane takes the next address.
- R4: A word read returns the next stream byte in [7:0] and the one after it in [15:8]. A low-byte read returns the next byte in [7:0] with [15:8] at 0. A high-byte read returns it in [15:8] with [7:0] at 0.
- R5: Word and byte transfers give the same byte order from an odd pointer as from an even pointer.
- R6: An even-address byte with its odd neighbour queued behind it is written as one memory word with `mem_be`=11. A lone even-address byte is not written while more bytes may still follow.
- R7: A pointer write holds `hst_rdy` low until the write queue is empty. A lone queued byte is then written with a one-lane mask (`mem_be` 01 for an even address, 10 for an odd one), and the other byte of that word is left unchanged.
- R8: A pointer write discards all prefetched read bytes and restarts the prefetch at the new pointer.
- R9: A data read that needs more bytes than the read queue holds keeps `hst_rdy` low until the prefetch has delivered them.
- R10: In fixed mode, data accesses do not move the position. Each write reaches memory with no later pointer write needed, and each read returns the bytes at the pointer.
- R11: After reset the pointer is 0, the mode is normal, `hst_rdy` is high while idle, and no memory write is issued.
- R12: `mem_re` and `mem_we` are never high in the same cycle. The prefetch waits while the write queue holds data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hst_addr | input | 3 | Host byte offset: bit 2 selects the pointer register, bit 0 is the byte lane |
| hst_hbe_n | input | 1 | Active-low high-byte enable |
| hst_rd | input | 1 | Read strobe, held until accepted |
| hst_wr | input | 1 | Write strobe, held until accepted |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid while `hst_rd` and `hst_rdy` are high |
| hst_rdy | output | 1 | High when the current strobe completes at this clock edge |
| mem_re | output | 1 | Memory word read request |
| mem_we | output | 1 | Memory word write request |
| mem_addr | output | PTR_W-1 | Memory word address |
| mem_be | output | 2 | Byte lane enables for a write |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_re` |

## Verification
Directed sequences cover the alignment cases. There are reads starting from an odd pointer with high-byte, word and low-byte sizes in turn, which separates lane placement errors from stream-order errors. A low byte followed by a high byte at an even pointer shows whether bytes merge or are committed early. A lone byte left behind by a pointer write exposes a wrong byte mask. Constrained-random runs from random pointers, in both modes, mix all four access forms, wrap around the top of the buffer, and end with a comparison of the whole memory image.

// File: rtl/dport_pkg.sv
// Package: shared types and helpers for the byte/word data port bridge.
// Assumes a 16-bit host bus and 16-bit memory words.
package dport_pkg;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_LO   = 2'd1,
        SZ_HI   = 2'd2,
        SZ_WORD = 2'd3
    } dp_size_e;

    // Map lane address bit and high-byte enable to an access size.
    function automatic dp_size_e dp_decode(input logic a0, input logic hbe_n);
        case ({a0, hbe_n})
            2'b00:   return SZ_WORD;
            2'b01:   return SZ_LO;
            2'b10:   return SZ_HI;
            default: return SZ_NONE;
        endcase
    endfunction

    // Number of bytes moved by one access of the given size.
    function automatic logic [1:0] dp_nbytes(input dp_size_e s);
        case (s)
            SZ_WORD: return 2'd2;
            SZ_NONE: return 2'd0;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/dport_fifo.sv
// Module: circular queue that takes up to two entries per cycle and
// releases up to two per cycle. It exposes the two oldest entries.
// Assumes DEPTH is a power of two, at least 2. The caller never pushes
// beyond free space or pops beyond the count. Clear wins over push and pop.
module dport_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  push_d0,
    input  logic [W-1:0]  push_d1,
    input  logic [1:0]    pop_n,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1,
    output logic [CW-1:0] count
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [W-1:0]  slot [DEPTH];
    logic [AW-1:0] rd_idx, wr_idx, rd_nxt, wr_nxt;
    logic [CW-1:0] cnt_q;

    assign rd_nxt = rd_idx + ONE;
    assign wr_nxt = wr_idx + ONE;
    assign head0  = slot[rd_idx];
    assign head1  = slot[rd_nxt];
    assign count  = cnt_q;

    // Store pushed entries; storage needs no reset.
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) slot[wr_idx] <= push_d0;
        if (push_n == 2'd2) slot[wr_nxt] <= push_d1;
    end

    // Move the indices and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_idx <= '0;
            wr_idx <= '0;
            cnt_q  <= '0;
        end else begin
            wr_idx <= wr_idx + AW'(push_n);
            rd_idx <= rd_idx + AW'(pop_n);
            cnt_q  <= cnt_q + CW'(push_n) - CW'(pop_n);
        end
    end

endmodule

// File: rtl/dport_wr_pack.sv
// Module: decides which memory write the write queue issues this cycle.
// Each entry is {byte address, byte}. An odd head byte goes out alone in
// the high lane. An even head byte waits for its odd neighbour, or goes
// out alone in the low lane when a flush is requested or when the entry
// behind it is not its neighbour. Purely combinational.
module dport_wr_pack #(
    parameter int PTR_W = 10,
    parameter int CNT_W = 4,
    localparam int ENT_W = PTR_W + 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [ENT_W-1:0] ent0,
    input  logic [ENT_W-1:0] ent1,
    input  logic             flush,
    output logic             go,
    output logic [PTR_W-2:0] waddr,
    output logic [1:0]       be,
    output logic [15:0]      wdata,
    output logic [1:0]       pop_n
);
    logic [PTR_W-1:0] a0, a1, a0_nx;
    logic [7:0]       b0, b1;

    assign a0    = ent0[ENT_W-1:8];
    assign b0    = ent0[7:0];
    assign a1    = ent1[ENT_W-1:8];
    assign b1    = ent1[7:0];
    assign a0_nx = a0 + PTR_W'(1);
    assign waddr = a0[PTR_W-1:1];

    // Choose the write form and how many entries leave.
    always_comb begin
        go    = 1'b0;
        be    = 2'b00;
        pop_n = 2'd0;
        wdata = {b0, b0};
        if (cnt != '0) begin
            if (a0[0]) begin
                go    = 1'b1;
                be    = 2'b10;
                pop_n = 2'd1;
            end else if (cnt >= CNT_W'(2) && a1 == a0_nx) begin
                go    = 1'b1;
                be    = 2'b11;
                pop_n = 2'd2;
                wdata = {b1, b0};
            end else if (cnt >= CNT_W'(2) || flush) begin
                go    = 1'b1;
                be    = 2'b01;
                pop_n = 2'd1;
            end
        end
    end

endmodule

// File: rtl/dport_rd_fetch.sv
// Module: read prefetcher. It keeps at most one memory read in flight and
// pushes the returned bytes from the current fetch position into the read
// queue. An odd position yields only the high byte. A restart moves the
// position and drops any data that arrives in the same cycle.
// Assumes a fixed memory read latency of one cycle.
module dport_rd_fetch #(
    parameter int PTR_W = 10,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    q_count,
    input  logic             allow,
    input  logic             restart,
    input  logic [PTR_W-1:0] restart_ptr,
    input  logic [15:0]      mem_rdata,
    output logic             fetch_go,
    output logic [PTR_W-2:0] fetch_addr,
    output logic [1:0]       push_n,
    output logic [7:0]       push_d0,
    output logic [7:0]       push_d1
);
    logic [PTR_W-1:0] fptr;
    logic             pend, pend_odd;

    assign fetch_go   = allow && !pend && !restart && (int'(q_count) <= DEPTH - 2);
    assign fetch_addr = fptr[PTR_W-1:1];
    assign push_n     = (pend && !restart) ? (pend_odd ? 2'd1 : 2'd2) : 2'd0;
    assign push_d0    = pend_odd ? mem_rdata[15:8] : mem_rdata[7:0];
    assign push_d1    = mem_rdata[15:8];

    // Track the fetch position and the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fptr     <= '0;
            pend     <= 1'b0;
            pend_odd <= 1'b0;
        end else begin
            pend <= fetch_go;
            if (fetch_go) pend_odd <= fptr[0];
            if (restart)       fptr <= restart_ptr;
            else if (fetch_go) fptr <= fptr + (fptr[0] ? PTR_W'(1) : PTR_W'(2));
        end
    end

endmodule

// File: rtl/dport_bridge.sv
// Module: host data port bridge. It decodes host accesses, keeps the write
// position and the mode, steers bytes into the write queue, serves reads
// from the prefetched read queue, and shares the memory port between the
// write drain and the prefetch. Assumes strobes are held until hst_rdy and
// that rd and wr are never high together. Data written in normal mode is
// visible to reads only after a pointer write.
module dport_bridge #(
    parameter int PTR_W    = 10,
    parameter int WR_DEPTH = 8,
    parameter int RD_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       hst_addr,
    input  logic             hst_hbe_n,
    input  logic             hst_rd,
    input  logic             hst_wr,
    input  logic [15:0]      hst_wdata,
    output logic [15:0]      hst_rdata,
    output logic             hst_rdy,
    output logic             mem_re,
    output logic             mem_we,
    output logic [PTR_W-2:0] mem_addr,
    output logic [1:0]       mem_be,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata
);
    import dport_pkg::*;

    localparam int WCW   = $clog2(WR_DEPTH + 1);
    localparam int RCW   = $clog2(RD_DEPTH + 1);
    localparam int ENT_W = PTR_W + 8;

    logic [PTR_W-1:0] wr_ptr_q, base_ptr_q;
    logic             fixed_q;
    dp_size_e         sz;
    logic [1:0]       nb;
    logic             is_ptr, wr_acc, rd_acc, ptr_load, dwr, drd;
    logic             restart, flush;
    logic [PTR_W-1:0] restart_ptr, new_ptr;
    logic [WCW-1:0]   wcnt;
    logic [RCW-1:0]   rcnt;
    logic [ENT_W-1:0] wq0, wq1, went0, went1;
    logic [7:0]       rq0, rq1, rpush0, rpush1, wb0;
    logic [1:0]       wpop, rpush;
    logic             wgo, fgo;
    logic [PTR_W-2:0] waddr, faddr;

    assign sz       = dp_decode(hst_addr[0], hst_hbe_n);
    assign nb       = dp_nbytes(sz);
    assign is_ptr   = hst_addr[2];
    assign new_ptr  = hst_wdata[PTR_W-1:0];
    assign wr_acc   = hst_wr && hst_rdy;
    assign rd_acc   = hst_rd && !hst_wr && hst_rdy;
    assign ptr_load = wr_acc && is_ptr;
    assign dwr      = wr_acc && !is_ptr && (sz != SZ_NONE);
    assign drd      = rd_acc && !is_ptr && (sz != SZ_NONE);
    assign restart  = ptr_load || (drd && fixed_q);
    assign restart_ptr = ptr_load ? new_ptr : base_ptr_q;
    assign flush    = fixed_q || (hst_wr && is_ptr);

    // Decide whether the pending host strobe completes this cycle.
    always_comb begin
        hst_rdy = 1'b1;
        if (hst_wr) begin
            if (is_ptr) hst_rdy = (wcnt == '0);
            else        hst_rdy = (int'(wcnt) + int'(nb) <= WR_DEPTH);
        end else if (hst_rd && !is_ptr) begin
            hst_rdy = (int'(rcnt) >= int'(nb));
        end
    end

    // Place read queue bytes on the lanes the access size selects.
    always_comb begin
        hst_rdata = 16'h0000;
        if (!is_ptr) begin
            case (sz)
                SZ_WORD: hst_rdata = {rq1, rq0};
                SZ_LO:   hst_rdata = {8'h00, rq0};
                SZ_HI:   hst_rdata = {rq0, 8'h00};
                default: hst_rdata = 16'h0000;
            endcase
        end
    end

    // Hold the write position, the pointer base and the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q   <= '0;
            base_ptr_q <= '0;
            fixed_q    <= 1'b0;
        end else if (ptr_load) begin
            wr_ptr_q   <= new_ptr;
            base_ptr_q <= new_ptr;
            fixed_q    <= hst_wdata[15];
        end else if (dwr && !fixed_q) begin
            wr_ptr_q   <= wr_ptr_q + PTR_W'(nb);
        end
    end

    assign wb0   = (sz == SZ_HI) ? hst_wdata[15:8] : hst_wdata[7:0];
    assign went0 = {wr_ptr_q, wb0};
    assign went1 = {wr_ptr_q + PTR_W'(1), hst_wdata[15:8]};

    dport_fifo #(.W(ENT_W), .DEPTH(WR_DEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n), .clear(1'b0),
        .push_n(dwr ? nb : 2'd0), .push_d0(went0), .push_d1(went1),
        .pop_n(wpop), .head0(wq0), .head1(wq1), .count(wcnt)
    );

    dport_wr_pack #(.PTR_W(PTR_W), .CNT_W(WCW)) u_pack (
        .cnt(wcnt), .ent0(wq0), .ent1(wq1), .flush(flush),
        .go(wgo), .waddr(waddr), .be(mem_be), .wdata(mem_wdata), .pop_n(wpop)
    );

    dport_rd_fetch #(.PTR_W(PTR_W), .DEPTH(RD_DEPTH)) u_fetch (
        .clk(clk), .rst_n(rst_n), .q_count(rcnt), .allow(wcnt == '0),
        .restart(restart), .restart_ptr(restart_ptr), .mem_rdata(mem_rdata),
        .fetch_go(fgo), .fetch_addr(faddr), .push_n(rpush),
        .push_d0(rpush0), .push_d1(rpush1)
    );

    dport_fifo #(.W(8), .DEPTH(RD_DEPTH)) u_rq (
        .clk(clk), .rst_n(rst_n), .clear(restart),
        .push_n(rpush), .push_d0(rpush0), .push_d1(rpush1),
        .pop_n(drd ? nb : 2'd0), .head0(rq0), .head1(rq1), .count(rcnt)
    );

    assign mem_we   = wgo;
    assign mem_re   = fgo;
    assign mem_addr = wgo ? waddr : faddr;

endmodule

// File: rtl/dport_bridge_chk.sv
// Module: property checker for dport_bridge, attached with bind.
// Watches the host and memory ports plus the mode and write position.
module dport_bridge_chk #(
    parameter int PTR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       hst_addr,
    input logic             hst_hbe_n,
    input logic             hst_wr,
    input logic             hst_rdy,
    input logic             mem_re,
    input logic             mem_we,
    input logic [1:0]       mem_be,
    input logic             fixed_q,
    input logic [PTR_W-1:0] wr_ptr_q
);
    // R12
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R7
    ptr_load_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_addr[2] && hst_rdy) |-> !mem_we);

    // R6
    write_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be != 2'b00));

    // R1
    bad_size_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && !hst_addr[2] && hst_addr[0] && hst_hbe_n) |=> $stable(wr_ptr_q));

    // R10
    fixed_no_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_q && hst_wr && !hst_addr[2] && hst_rdy) |=> $stable(wr_ptr_q));

    // R11
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mem_we && hst_rdy));

endmodule

bind dport_bridge dport_bridge_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_hbe_n(hst_hbe_n),
    .hst_wr(hst_wr), .hst_rdy(hst_rdy), .mem_re(mem_re), .mem_we(mem_we),
    .mem_be(mem_be), .fixed_q(fixed_q), .wr_ptr_q(wr_ptr_q)
);

// File: tb/dport_bridge_bench.sv
// Bench: directed corner cases plus seeded random runs against a byte model.
module dport_bridge_bench;
    localparam int PTR_W = 10;
    localparam int NB    = 1 << PTR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0]  hst_addr = '0;
    logic        hst_hbe_n = 1'b0, hst_rd = 1'b0, hst_wr = 1'b0;
    logic [15:0] hst_wdata = '0, hst_rdata;
    logic        hst_rdy, mem_re, mem_we;
    logic [PTR_W-2:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem [NB/2];
    logic [7:0]  expb [NB];
    logic [9:0]  wp = '0, rp = '0;
    logic        fxm = 1'b0;
    int nchk = 0, nerr = 0, nwr = 0, nboth = 0;
    logic [1:0] last_be = '0;
    logic finished = 1'b0;

    always #10 clk = ~clk;

    dport_bridge #(.PTR_W(PTR_W), .WR_DEPTH(8), .RD_DEPTH(8)) u_dport_bridge (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_hbe_n(hst_hbe_n),
        .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_rdy(hst_rdy), .mem_re(mem_re),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] ib(input int a);
        return 8'(a * 29 + 11);
    endfunction

    // Buffer memory model with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
            nwr++;
            last_be <= mem_be;
        end
        if (mem_we && mem_re) nboth++;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exv);
        nchk++;
        if (act !== exv) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    task automatic acc(input logic wr, input logic [2:0] a, input logic hbe,
                       input logic [15:0] wd, output logic [15:0] rd, output int waits);
        @(negedge clk);
        hst_wr = wr; hst_rd = ~wr; hst_addr = a; hst_hbe_n = hbe; hst_wdata = wd;
        waits = 0;
        while (1) begin
            #5;
            if (hst_rdy) break;
            waits++;
            @(negedge clk);
        end
        rd = hst_rdata;
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b0;
    endtask

    task automatic load(input logic [9:0] p, input logic fx, output int w);
        logic [15:0] d;
        acc(1'b1, 3'b100, 1'b0, {fx, 5'b0, p}, d, w);
        wp = p; rp = p; fxm = fx;
    endtask

    // kind: 0 word at offset 0, 1 word at offset 2, 2 low byte, 3 high byte
    task automatic dwrite(input int kind, input logic [15:0] d);
        logic [15:0] r; int w;
        logic [2:0] a = (kind == 1) ? 3'b010 : (kind == 3) ? 3'b001 : 3'b000;
        acc(1'b1, a, kind == 2, d, r, w);
        expb[wp] = (kind == 3) ? d[15:8] : d[7:0];
        if (kind < 2) expb[10'(wp + 1)] = d[15:8];
        if (!fxm) wp = wp + ((kind < 2) ? 10'd2 : 10'd1);
    endtask

    task automatic dread(input int kind, input string req, output int w);
        logic [15:0] r, e;
        logic [2:0] a = (kind == 1) ? 3'b010 : (kind == 3) ? 3'b001 : 3'b000;
        acc(1'b0, a, kind == 2, 16'h0, r, w);
        if (kind < 2)       e = {expb[10'(rp + 1)], expb[rp]};
        else if (kind == 2) e = {8'h00, expb[rp]};
        else                e = {expb[rp], 8'h00};
        chk(req, r, e);
        if (!fxm) rp = rp + ((kind < 2) ? 10'd2 : 10'd1);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(20 * 200000);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int w, base, mism;
        logic [15:0] r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) expb[i] = ib(i);
        for (int i = 0; i < NB / 2; i++) mem[i] = {ib(2 * i + 1), ib(2 * i)};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 rdy idle", hst_rdy, 1);
        chk("R11 no write", mem_we, 0);
        dread(0, "R11 start at 0", w);

        // R9: empty queue after a pointer write stalls the read
        load(10'h040, 1'b0, w);
        dread(0, "R9 data", w);
        chk("R9 wait", w > 0, 1);

        // R5/R4/R2: odd pointer, mixed sizes, second word offset
        load(10'h041, 1'b0, w);
        dread(3, "R5 high byte odd", w);
        dread(0, "R5 word odd", w);
        dread(2, "R4 low byte", w);
        dread(1, "R2 word at offset 2", w);

        // R6: lone even byte waits, then merges
        load(10'h080, 1'b0, w);
        base = nwr;
        dwrite(2, 16'h00AA);
        repeat (3) @(negedge clk);
        chk("R6 lone byte held", nwr - base, 0);
        dwrite(3, 16'hBB00);
        repeat (3) @(negedge clk);
        chk("R6 single write", nwr - base, 1);
        chk("R6 full mask", last_be, 2'b11);
        chk("R6 merged word", mem[10'h080 >> 1], 16'hBBAA);

        // R7: pointer write drains a lone byte with a one-lane mask
        load(10'h090, 1'b0, w);
        dwrite(2, 16'h00CC);
        load(10'h100, 1'b0, w);
        chk("R7 load waited", w > 0, 1);
        chk("R7 low mask", last_be, 2'b01);
        chk("R7 neighbour kept", mem[10'h090 >> 1], {ib(10'h091), 8'hCC});

        // R1: undefined size moves nothing
        acc(1'b1, 3'b001, 1'b1, 16'hFFFF, r, w);
        dwrite(0, 16'h1234);
        load(10'h100, 1'b0, w);
        acc(1'b0, 3'b011, 1'b1, 16'h0, r, w);
        chk("R1 undefined read", r, 16'h0000);
        dread(0, "R1 data after undefined", w);

        // R8: reload flushes prefetched bytes
        load(10'h300, 1'b0, w);
        dread(2, "R8 first area", w);
        load(10'h010, 1'b0, w);
        dread(2, "R8 new area", w);

        // R10: fixed mode
        load(10'h020, 1'b1, w);
        dread(0, "R10 read 1", w);
        dread(0, "R10 read 2", w);
        dwrite(0, 16'h7777);
        repeat (3) @(negedge clk);
        chk("R10 write reached memory", mem[10'h020 >> 1], 16'h7777);
        dwrite(2, 16'h0011);
        load(10'h020, 1'b0, w);
        dread(0, "R10 stayed on pointer", w);

        // Random runs over both modes and all access forms
        for (int run = 0; run < 80; run++) begin
            logic [9:0] p = 10'($urandom);
            logic fx = ($urandom % 4) == 0;
            logic dir = 1'($urandom);
            int n = 1 + int'($urandom % 10);
            if (fx) p[0] = 1'b0;
            load(p, fx, w);
            for (int k = 0; k < n; k++) begin
                int kind = int'($urandom % 4);
                if (dir) dwrite(kind, 16'($urandom));
                else     dread(kind, "R3 R4 random read", w);
            end
        end
        load(10'h000, 1'b0, w);
        mism = 0;
        for (int i = 0; i < NB / 2; i++)
            if (mem[i] !== {expb[2 * i + 1], expb[2 * i]}) mism++;
        chk("R3 memory image mismatches", mism, 0);
        chk("R12 read and write together", nboth, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule